// File: doc/BRIEF.md
# Windowed Packet Rate Meter

This block measures packet throughput. It counts start-of-packet strobes over a window of clock cycles that the host programs. The host first writes the window length into a 32-bit register. It then writes 1 to the go bit. In that same clock edge the block clears its packet count and loads a cycle down-counter from the window register. On each of the following cycles it adds any strobe to the count, until the window has run out.

When the window expires, the go bit drops back to 0 without any host action. Software polls the go bit, and a 0 tells it the result is ready. The frozen count then stays readable until the next start. Turning the count into a rate per second is left to software.

The host side is a single-cycle write port and a combinational read port. Registers are selected by a 2-bit address: 0 is the window length, 1 is the go bit at bit 0, 2 is the packet count, and 3 is unused.

Top module: `pkt_rate_meter`

## Requirements
- R1: After reset, address 0 (window length), address 1 (go bit) and address 2 (count) all read 0.
- R2: A write to address 0 stores all 32 data bits as the window length, and a read of address 0 returns them.
- R3: A write to address 1 with data bit 0 set starts a measurement. On that clock edge the count becomes 0 and the go bit becomes 1.
- R4: With a window length N of 1 or more, the go bit reads 1 for exactly N cycles after the start edge and then reads 0.
- R5: A strobe adds 1 to the count only when it is sampled on one of the N clock edges after the start edge. Strobes on the start edge or after the window has ended are ignored, and the count holds.
- R6: With a window length of 0, the go bit reads 1 for one cycle, and the count ends at 0 whatever the strobe does.
- R7: A go write while a window is running restarts it. The count is cleared and the full window length is loaded again.
- R8: The count saturates at all ones and never wraps to 0.
- R9: A write of data bit 0 = 0 to address 1, and any write to address 2 or 3, changes neither the go bit nor the count.
- R10: The window length is captured at the start edge. Rewriting address 0 during a window changes only later measurements.
- R11: Address 3 reads 0. A count narrower than the data bus reads zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| sop | input | 1 | Start-of-packet strobe, one per packet |

## Verification
The strobe is driven in four patterns: on every cycle, on alternate cycles, held low, and held high across both edges of the window. Continuous strobing shows whether the window is exactly N counted edges. Strobing on alternate cycles shows whether the first and last window edges are both included. Strobes on the start edge and after expiry show whether anything outside the window leaks into the count.

Further runs cover:
- a restart in mid-window;
- a window-length rewrite in mid-window;
- a zero-length window;
- a window long enough to saturate a narrowed count, which shows saturation apart from wrapping.

// File: rtl/prm_pkg.sv
package prm_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_WIN  = 2'd0,
        ADR_GO   = 2'd1,
        ADR_CNT  = 2'd2,
        ADR_NONE = 2'd3
    } adr_e;

endpackage

// File: rtl/prm_host_if.sv
module prm_host_if #(
    parameter int DATA_W = 32,
    parameter int WIN_W  = 32,
    parameter int CNT_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [prm_pkg::ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [prm_pkg::ADDR_W-1:0] rd_addr,
    input  logic                      busy,
    input  logic [CNT_W-1:0]          count,
    output logic [WIN_W-1:0]          win_len,
    output logic                      start,
    output logic [DATA_W-1:0]         rd_data
);
    import prm_pkg::*;

    typedef struct packed {
        logic [WIN_W-1:0] win;
    } host_st_t;

    host_st_t st_d, st_q;

    // Next-state and decode
    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (wr_en) begin
            case (adr_e'(wr_addr))
                ADR_WIN: st_d.win = wr_data[WIN_W-1:0];
                ADR_GO:  start    = wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_len = st_q.win;

    // Read mux
    always_comb begin
        case (adr_e'(rd_addr))
            ADR_WIN: rd_data = DATA_W'(st_q.win);
            ADR_GO:  rd_data = DATA_W'(busy);
            ADR_CNT: rd_data = DATA_W'(count);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/prm_window.sv
module prm_window #(
    parameter int WIN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIN_W-1:0] win_len,
    output logic             busy,
    output logic             active,
    output logic [WIN_W-1:0] rem
);
    typedef struct packed {
        logic             busy;
        logic [WIN_W-1:0] rem;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.rem <= WIN_W'(1)) st_d.busy = 1'b0;
            if (st_q.rem != '0)        st_d.rem  = st_q.rem - 1'b1;
        end
        if (start) begin
            st_d.busy = 1'b1;
            st_d.rem  = win_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign rem    = st_q.rem;
    assign active = st_q.busy && (st_q.rem != '0);
endmodule

// File: rtl/prm_tally.sv
module prm_tally #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             active,
    input  logic             sop,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tally_st_t;

    tally_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (active && sop && (st_q.cnt != CNT_MAX))
            st_d.cnt = st_q.cnt + 1'b1;
        if (start)
            st_d.cnt = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/pkt_rate_meter.sv
module pkt_rate_meter #(
    parameter int DATA_W = 32,
    parameter int WIN_W  = 32,
    parameter int CNT_W  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic        sop
);
    logic [WIN_W-1:0] win_len;
    logic [WIN_W-1:0] win_rem;
    logic             go_start;
    logic             win_busy;
    logic             win_active;
    logic [CNT_W-1:0] sop_count;

    prm_host_if #(.DATA_W(DATA_W), .WIN_W(WIN_W), .CNT_W(CNT_W)) u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .busy    (win_busy),
        .count   (sop_count),
        .win_len (win_len),
        .start   (go_start),
        .rd_data (rd_data)
    );

    prm_window #(.WIN_W(WIN_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (go_start),
        .win_len (win_len),
        .busy    (win_busy),
        .active  (win_active),
        .rem     (win_rem)
    );

    prm_tally #(.CNT_W(CNT_W)) u_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (go_start),
        .active (win_active),
        .sop    (sop),
        .count  (sop_count)
    );
endmodule

// File: rtl/prm_chk.sv
module prm_chk #(
    parameter int WIN_W = 32,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             sop,
    input logic             busy,
    input logic [WIN_W-1:0] rem,
    input logic [WIN_W-1:0] win_len,
    input logic [CNT_W-1:0] count
);
    // R3
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && count == '0));

    // R4
    window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rem == '0 && !start) |=> !busy);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(count));

    // R5
    no_sop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sop && !start) |=> $stable(count));

    // R6
    zero_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && win_len == '0) |=> ##1 (!busy || $past(start)));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '1 && !start) |=> count == '1);
endmodule

bind pkt_rate_meter prm_chk #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (go_start),
    .sop     (sop),
    .busy    (win_busy),
    .rem     (win_rem),
    .win_len (win_len),
    .count   (sop_count)
);

// File: tb/sim_pkt_rate_meter.sv
`timescale 1ns/1ps
module sim_pkt_rate_meter;
    localparam int CW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        sop = 1'b0;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    // Behavioural reference state
    longint m_win = 0, m_rem = 0, m_cnt = 0;
    bit     m_busy = 0;
    longint CMAX = (64'd1 << CW) - 1;

    always #2 clk = ~clk;

    pkt_rate_meter #(.DATA_W(32), .WIN_W(32), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sop(sop)
    );

    function automatic longint m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_win;
            2'd1: return longint'(m_busy);
            2'd2: return m_cnt;
            default: return 0;
        endcase
    endfunction

    task automatic m_step();
        bit st;
        st = wr_en && wr_addr == 2'd1 && wr_data[0];
        if (m_busy) begin
            if (m_rem != 0 && sop && m_cnt < CMAX) m_cnt++;
            if (m_rem <= 1) m_busy = 0;
            if (m_rem != 0) m_rem--;
        end
        if (wr_en && wr_addr == 2'd0) m_win = wr_data;
        if (st) begin
            m_busy = 1; m_rem = m_win; m_cnt = 0;
        end
    endtask

    task automatic check(input string tag, input longint got, input longint exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input longint exp, input string tag);
        rd_addr = a;
        #0.1;
        check(tag, longint'(rd_data), exp);
    endtask

    // One clock: compare against model, advance model at the edge
    task automatic cyc();
        #0.1;
        check({cur_req, " model"}, longint'(rd_data), m_read(rd_addr));
        @(posedge clk);
        m_step();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit s);
        wr_en = 1'b1; wr_addr = a; wr_data = d; sop = s;
        cyc();
    endtask

    // pattern: 0 none, 1 every cycle, 2 alternate starting high
    task automatic run(input int n, input int pattern);
        for (int i = 0; i < n; i++) begin
            sop = (pattern == 1) || (pattern == 2 && (i % 2) == 0);
            rd_addr = 2'd2;
            cyc();
        end
        sop = 1'b0;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
        end
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        cur_req = "R1";
        rd(2'd0, 0, "R1 win"); rd(2'd1, 0, "R1 go"); rd(2'd2, 0, "R1 cnt");

        // R2
        cur_req = "R2";
        wr(2'd0, 32'hA5A5_5A5A, 1'b0);
        rd(2'd0, 32'hA5A5_5A5A, "R2 readback");
        wr(2'd0, 32'd5, 1'b0);

        // R3 R4 R5: continuous strobes
        cur_req = "R3";
        wr(2'd1, 32'd1, 1'b1);
        rd(2'd1, 1, "R3 go set"); rd(2'd2, 0, "R3 cnt clear");
        cur_req = "R4";
        run(4, 1);
        rd(2'd1, 1, "R4 go still high");
        run(1, 1);
        rd(2'd1, 0, "R4 go dropped");
        rd(2'd2, 5, "R5 full window count");
        cur_req = "R5";
        run(3, 1);
        rd(2'd2, 5, "R5 frozen after window");

        // R5: alternate strobes, window 7
        wr(2'd0, 32'd7, 1'b0);
        wr(2'd1, 32'd1, 1'b1);
        run(7, 2);
        rd(2'd1, 0, "R4 go low after 7");
        rd(2'd2, 4, "R5 alternate count");

        // R6 zero window
        cur_req = "R6";
        wr(2'd0, 32'd0, 1'b0);
        wr(2'd1, 32'd1, 1'b1);
        rd(2'd1, 1, "R6 go one cycle");
        run(1, 1);
        rd(2'd1, 0, "R6 go dropped");
        rd(2'd2, 0, "R6 zero count");

        // R7 restart
        cur_req = "R7";
        wr(2'd0, 32'd6, 1'b0);
        wr(2'd1, 32'd1, 1'b0);
        run(3, 1);
        rd(2'd2, 3, "R7 partial");
        wr(2'd1, 32'd1, 1'b1);
        rd(2'd2, 0, "R7 cleared on restart");
        run(5, 1);
        rd(2'd1, 1, "R7 window reloaded");
        run(1, 1);
        rd(2'd2, 6, "R7 restart count");

        // R10 window rewrite mid-run
        cur_req = "R10";
        wr(2'd0, 32'd8, 1'b0);
        wr(2'd1, 32'd1, 1'b0);
        run(2, 1);
        wr(2'd0, 32'd2, 1'b1);
        run(4, 1);
        rd(2'd1, 1, "R10 old window kept");
        run(1, 1);
        rd(2'd1, 0, "R10 go dropped");
        rd(2'd2, 8, "R10 count");
        rd(2'd0, 2, "R10 new length stored");

        // R9 ignored writes
        cur_req = "R9";
        wr(2'd0, 32'd4, 1'b0);
        wr(2'd1, 32'd1, 1'b0);
        run(1, 1);
        wr(2'd1, 32'd0, 1'b1);
        wr(2'd2, 32'hFF, 1'b1);
        wr(2'd3, 32'hFFFF_FFFF, 1'b1);
        rd(2'd1, 0, "R9 go ended normally");
        rd(2'd2, 4, "R9 count unaffected");
        wr(2'd1, 32'd2, 1'b1);
        rd(2'd1, 0, "R9 bit0 clear no start");
        rd(2'd2, 4, "R9 count kept");

        // R8 saturation
        cur_req = "R8";
        wr(2'd0, 32'd100, 1'b0);
        wr(2'd1, 32'd1, 1'b0);
        run(70, 1);
        rd(2'd2, 63, "R8 saturated");
        rd(2'd1, 1, "R8 still running");
        run(30, 1);
        rd(2'd2, 63, "R8 no wrap");

        // R11
        cur_req = "R11";
        rd(2'd3, 0, "R11 unused address");
        rd(2'd2, 63, "R11 zero extended");

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
        end
        $finish;
    end
endmodule